// File: doc/BRIEF.md
# Powerdown Sequencing Controller

This controller takes a processor core into a dormant low-power state and brings it back out. A request comes from an external sleep pin or from a software force bit, and either one is enough. The block does not halt the core at once. It first raises a single-cycle, non-maskable powerdown interrupt, so software can run for as long as it needs. The core is halted only when software issues the halt command. In the dormant state the core clock enable is low and an acknowledge output is high.

Wake-up starts when the synchronised sleep pin is released. The block then counts input-clock cycles before it raises the core clock enable again. The count is short when the oscillator was kept running and long when the oscillator was stopped and must settle. The count advances only on cycles in which the input clock is marked as active. At restart a one-cycle clear pulse tells the core whether to discard its context or resume where it stopped. Reset ends powerdown at any point. A configuration bit gates the clock output pin, and the pin also falls silent while the core is halted.

Top module: `pd_seq_top`

## Requirements
- R1: The sleep pin passes through a two-stage synchroniser. A rising edge seen in the running state gives exactly one `pdIrq` pulse, one cycle wide, in the third cycle after the pin rises. Holding the pin high gives no further pulse.
- R2: A rising edge of `swForce` in the running state gives one `pdIrq` pulse in the next cycle.
- R3: After `pdIrq` the core keeps running (`coreClkEn`=1, `pdAck`=0) until `haltCmd` is high. On the following cycle `coreClkEn` is 0 and `pdAck` is 1.
- R4: `pdAck` is high only in the powered-down state. It is low while running, while pending and during the restart wait.
- R5: A falling edge of the synchronised sleep pin in the powered-down state starts the restart wait. If `oscKeep`=1 at that time, `coreClkEn` returns SHORT_WAIT (100) active cycles after the wait begins. That is the 103rd cycle after the pin falls.
- R6: If `oscKeep`=0 at exit, the wait is LONG_WAIT (4096) active cycles. `coreClkEn` returns in cycle LONG_WAIT+3 after the pin falls.
- R7: The restart counter advances only on cycles with `clkActive`=1. Each inactive cycle delays the restart by one cycle.
- R8: `ctxKeep` is sampled at exit. If it was 0, `ctxClear` is high for exactly the first running cycle after restart. If it was 1, `ctxClear` stays low.
- R9: Asserting `rst_n` low ends powerdown at once. `coreClkEn` goes to 1 and `pdAck` to 0 without waiting for a clock edge.
- R10: `haltCmd` in the running state has no effect. A new pin or force edge while pending or powered down gives no `pdIrq`.
- R11: `clkOutOn` is 1 only when `clkOutCfg`=1 and the core clock is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset; ends powerdown |
| sleepPin | input | 1 | Asynchronous powerdown request pin, active high |
| swForce | input | 1 | Software force bit; its rising edge requests powerdown |
| haltCmd | input | 1 | Core halt command, accepted while pending |
| oscKeep | input | 1 | 1 = oscillator kept running (short wait), 0 = stopped (long wait) |
| ctxKeep | input | 1 | 1 = resume with saved context, 0 = clear it on restart |
| clkActive | input | 1 | Input clock toggling; gates the restart counter |
| clkOutCfg | input | 1 | Clock output pin enable bit |
| pdIrq | output | 1 | One-cycle non-maskable powerdown interrupt |
| coreClkEn | output | 1 | Core clock enable |
| pdAck | output | 1 | Powerdown acknowledge |
| ctxClear | output | 1 | One-cycle context clear pulse at restart |
| clkOutOn | output | 1 | Clock output pin enable |

## Verification
The entry path is driven in two ways: by a held sleep pin, and by a software force edge. The pin case shows the synchroniser latency and that a single edge gives a single interrupt. The force case shows the one-cycle path. Exits are run with the oscillator kept running and with it stopped, which separates the two wait lengths cycle for cycle. One exit pauses the active-clock flag part way through the wait, to show that only active cycles count. The context flag is set both ways so that the clear pulse and its absence are both seen. A reset in the middle of powerdown and stray halt and request edges cover the paths that must leave the state alone.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_PENDING = 2'd1,
    ST_DOWN    = 2'd2,
    ST_WAKE    = 2'd3
  } pdState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic restartDone;
  } pdStrobe_t;
endpackage

// File: rtl/pd_seq_datapath.sv
module pd_seq_datapath
  import pd_seq_pkg::*;
#(
  parameter int SHORT_WAIT = 100,
  parameter int LONG_WAIT  = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleepPin,
  input  logic      swForce,
  input  logic      oscKeep,
  input  logic      ctxKeep,
  input  pdStrobe_t strobe,
  output logic      pinRise,
  output logic      pinFall,
  output logic      swRise,
  output logic      cntZero,
  output logic      ctxClear
);
  localparam int CNT_W = $clog2(LONG_WAIT + 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_WAIT - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_WAIT - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev;
  logic swPrev;
  logic [CNT_W-1:0] cntQ;
  logic ctxKeepQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
      swPrev  <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], sleepPin};
      pinPrev <= syncQ[SYNC_STAGES-1];
      swPrev  <= swForce;
    end
  end

  assign pinRise = syncQ[SYNC_STAGES-1] & ~pinPrev;
  assign pinFall = ~syncQ[SYNC_STAGES-1] & pinPrev;
  assign swRise  = swForce & ~swPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ     <= '0;
      ctxKeepQ <= 1'b1;
      ctxClear <= 1'b0;
    end else begin
      if (strobe.loadCnt) begin
        cntQ     <= oscKeep ? SHORT_LOAD : LONG_LOAD;
        ctxKeepQ <= ctxKeep;
      end else if (strobe.decCnt) begin
        cntQ <= cntQ - 1'b1;
      end
      ctxClear <= strobe.restartDone & ~ctxKeepQ;
    end
  end

  assign cntZero = (cntQ == '0);
endmodule

// File: rtl/pd_seq_control.sv
module pd_seq_control
  import pd_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pinRise,
  input  logic      pinFall,
  input  logic      swRise,
  input  logic      cntZero,
  input  logic      haltCmd,
  input  logic      clkActive,
  output pdStrobe_t strobe,
  output logic      pdIrq,
  output logic      coreClkEn,
  output logic      pdAck
);
  pdState_t stateQ, stateD;
  logic reqSeen;

  assign reqSeen = pinRise | swRise;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_RUN:     if (reqSeen) stateD = ST_PENDING;
      ST_PENDING: if (haltCmd) stateD = ST_DOWN;
      ST_DOWN: begin
        if (pinFall) begin
          stateD = ST_WAKE;
          strobe.loadCnt = 1'b1;
        end
      end
      ST_WAKE: begin
        if (clkActive) begin
          if (cntZero) begin
            stateD = ST_RUN;
            strobe.restartDone = 1'b1;
          end else begin
            strobe.decCnt = 1'b1;
          end
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_RUN;
      pdIrq  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pdIrq  <= (stateQ == ST_RUN) & reqSeen;
    end
  end

  assign coreClkEn = (stateQ == ST_RUN) || (stateQ == ST_PENDING);
  assign pdAck     = (stateQ == ST_DOWN);
endmodule

// File: rtl/pd_seq_top.sv
module pd_seq_top
  import pd_seq_pkg::*;
#(
  parameter int SHORT_WAIT = 100,
  parameter int LONG_WAIT  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleepPin,
  input  logic swForce,
  input  logic haltCmd,
  input  logic oscKeep,
  input  logic ctxKeep,
  input  logic clkActive,
  input  logic clkOutCfg,
  output logic pdIrq,
  output logic coreClkEn,
  output logic pdAck,
  output logic ctxClear,
  output logic clkOutOn
);
  pdStrobe_t strobe;
  logic pinRise, pinFall, swRise, cntZero;

  pd_seq_datapath #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT), .SYNC_STAGES(2)) dp_i (
    .clk(clk), .rst_n(rst_n), .sleepPin(sleepPin), .swForce(swForce),
    .oscKeep(oscKeep), .ctxKeep(ctxKeep), .strobe(strobe),
    .pinRise(pinRise), .pinFall(pinFall), .swRise(swRise),
    .cntZero(cntZero), .ctxClear(ctxClear)
  );

  pd_seq_control ctl_i (
    .clk(clk), .rst_n(rst_n), .pinRise(pinRise), .pinFall(pinFall),
    .swRise(swRise), .cntZero(cntZero), .haltCmd(haltCmd),
    .clkActive(clkActive), .strobe(strobe), .pdIrq(pdIrq),
    .coreClkEn(coreClkEn), .pdAck(pdAck)
  );

  assign clkOutOn = clkOutCfg & coreClkEn;
endmodule

// File: rtl/pd_seq_checker.sv
module pd_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic haltCmd,
  input logic clkOutCfg,
  input logic pdIrq,
  input logic coreClkEn,
  input logic pdAck,
  input logic ctxClear,
  input logic clkOutOn
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pdIrq |=> !pdIrq); // R1
  AST_IRQ_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    pdIrq |-> coreClkEn && !pdAck); // R3
  AST_ACK_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdAck) |-> $past(haltCmd)); // R3
  AST_ACK_CORE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    pdAck |-> !coreClkEn); // R4
  AST_EXIT_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pdAck) |-> !coreClkEn); // R5
  AST_CLEAR_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ctxClear |-> $rose(coreClkEn)); // R8
  AST_CLKOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    clkOutOn |-> coreClkEn && clkOutCfg); // R11
endmodule

bind pd_seq_top pd_seq_checker chk_i (
  .clk(clk), .rst_n(rst_n), .haltCmd(haltCmd), .clkOutCfg(clkOutCfg),
  .pdIrq(pdIrq), .coreClkEn(coreClkEn), .pdAck(pdAck),
  .ctxClear(ctxClear), .clkOutOn(clkOutOn)
);

// File: tb/pd_seq_top_tb_top.sv
module pd_seq_top_tb_top;
  localparam int SHORT_WAIT = 100;
  localparam int LONG_WAIT  = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepPin = 1'b0, swForce = 1'b0, haltCmd = 1'b0;
  logic oscKeep = 1'b1, ctxKeep = 1'b1, clkActive = 1'b1, clkOutCfg = 1'b1;
  logic pdIrq, coreClkEn, pdAck, ctxClear, clkOutOn;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pd_seq_top #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleepPin(sleepPin), .swForce(swForce),
    .haltCmd(haltCmd), .oscKeep(oscKeep), .ctxKeep(ctxKeep),
    .clkActive(clkActive), .clkOutCfg(clkOutCfg), .pdIrq(pdIrq),
    .coreClkEn(coreClkEn), .pdAck(pdAck), .ctxClear(ctxClear),
    .clkOutOn(clkOutOn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    tick(1);
    chk("R9 reset coreClkEn", coreClkEn, 1);
    chk("R9 reset pdAck", pdAck, 0);
    chk("R1 reset pdIrq", pdIrq, 0);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic testHaltIgnored();
    haltCmd = 1'b1;
    tick(1);
    haltCmd = 1'b0;
    tick(1);
    chk("R10 halt in run coreClkEn", coreClkEn, 1);
    chk("R10 halt in run pdAck", pdAck, 0);
  endtask

  task automatic testPinEntry();
    int pulses = 0;
    int firstIdx = 0;
    sleepPin = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick(1);
      if (pdIrq) begin
        pulses++;
        if (firstIdx == 0) firstIdx = i;
      end
    end
    chk("R1 pin irq pulse count", pulses, 1);
    chk("R1 pin irq latency", firstIdx, 3);
    chk("R3 pending coreClkEn", coreClkEn, 1);
    chk("R3 pending pdAck", pdAck, 0);
    chk("R11 clkOut while running", clkOutOn, 1);
    swForce = 1'b1;
    tick(1);
    chk("R10 force edge while pending", pdIrq, 0);
    swForce = 1'b0;
    haltCmd = 1'b1;
    tick(1);
    haltCmd = 1'b0;
    chk("R3 halted coreClkEn", coreClkEn, 0);
    chk("R3 halted pdAck", pdAck, 1);
    chk("R11 clkOut while halted", clkOutOn, 0);
  endtask

  task automatic testSwEntry();
    int firstIdx = 0;
    swForce = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      tick(1);
      if (pdIrq && firstIdx == 0) firstIdx = i;
    end
    chk("R2 force irq latency", firstIdx, 1);
    chk("R3 force pending pdAck", pdAck, 0);
    haltCmd = 1'b1;
    tick(1);
    haltCmd = 1'b0;
    swForce = 1'b0;
    chk("R3 force halted pdAck", pdAck, 1);
    sleepPin = 1'b1;
    tick(5);
    chk("R10 pin edge while down no irq", pdIrq, 0);
    chk("R4 still down pdAck", pdAck, 1);
  endtask

  task automatic testWake(input logic osc, input logic ctx, input int waitLen,
                          input int gap, input string req);
    int riseIdx = 0;
    int ackDuring = 0;
    oscKeep = osc;
    ctxKeep = ctx;
    sleepPin = 1'b0;
    for (int i = 1; i <= waitLen + gap + 20; i++) begin
      clkActive = !(i >= 10 && i < 10 + gap);
      tick(1);
      if (i >= 3 && !coreClkEn && pdAck) ackDuring++;
      if (coreClkEn && riseIdx == 0) begin
        riseIdx = i;
        chk({req, " ctxClear at restart"}, ctxClear, ctx ? 0 : 1);
        break;
      end
    end
    clkActive = 1'b1;
    chk({req, " restart cycle"}, riseIdx, waitLen + gap + 3);
    chk("R4 no ack in wait", ackDuring, 0);
    tick(1);
    chk("R8 ctxClear one cycle", ctxClear, 0);
    chk({req, " running pdAck"}, pdAck, 0);
  endtask

  task automatic testResetExit();
    swForce = 1'b1;
    tick(1);
    swForce = 1'b0;
    haltCmd = 1'b1;
    tick(1);
    haltCmd = 1'b0;
    chk("R9 pre-reset pdAck", pdAck, 1);
    #2 rst_n = 1'b0;
    #1;
    chk("R9 async reset coreClkEn", coreClkEn, 1);
    chk("R9 async reset pdAck", pdAck, 0);
    tick(1);
    rst_n = 1'b1;
    tick(2);
    clkOutCfg = 1'b0;
    tick(1);
    chk("R11 clkOut cfg off", clkOutOn, 0);
  endtask

  initial begin
    testReset();
    testHaltIgnored();
    testPinEntry();
    testWake(1'b1, 1'b1, SHORT_WAIT, 0, "R5");
    testSwEntry();
    testWake(1'b0, 1'b0, LONG_WAIT, 0, "R6");
    testPinEntry();
    testWake(1'b1, 1'b0, SHORT_WAIT, 7, "R7");
    testResetExit();
    finishRun();
  end
endmodule